// File: doc/BRIEF.md
# PCM Highway Slot Serializer

This block places one channel's companded sample onto a serial PCM highway. A frame begins on the rising edge of the frame sync. The block counts bit periods from that point and drives its assigned time slot MSB first. The tri-state drive enable is high only while the block owns the line.

The bit period is one clock in normal mode. In double-clock mode it is two clocks, so the data rate is half the clock rate. When signaling mode and companded mode are both selected, a second slot follows the data slot with no gap. That slot carries a status byte built from the two detector inputs and the fail flag.

The slot number, the mode bits, the data byte and the status inputs are all captured on the frame-start edge. They stay fixed for the whole frame. The signaling slot is still driven when the channel is inactive; the data slot is not.

Top module: `pcm_slot_tx`

## Requirements
- R1: After reset, and before the first frame start, `doe_o` and `dout_o` are 0.
- R2: A rising edge of `fsync_i` sampled on a clock edge starts a frame. The clock period after that edge is bit period 0. Slot N bit k (k=0 for the MSB) is driven in bit period 8N+k.
- R3: With `dbl_clk_i`=0 captured, each bit period lasts one clock.
- R4: With `dbl_clk_i`=1 captured, each bit period lasts two clocks.
- R5: When `chan_act_i`=1, the data byte is driven MSB first in slot `slot_i`, with `doe_o`=1.
- R6: When `sig_mode_i`=1 and `comp_en_i`=1, slot `slot_i`+1 carries the signaling byte MSB first. Its layout is bit7=`cd1_i`, bit6=`cd2_i`, bit2=`cfail_i`, and bits 5..3 and 1..0 are 0. Its bit 7 follows data bit 0 with no gap.
- R7: When either `sig_mode_i` or `comp_en_i` is 0, no signaling slot is driven.
- R8: When `chan_act_i`=0, the data slot is not driven, but the signaling slot still is.
- R9: Outside the driven slots, `doe_o`=0 and `dout_o`=0.
- R10: Input changes after the frame-start edge have no effect until the next frame start.
- R11: A frame spans NSLOT*8 bit periods and nothing is driven after it ends. A signaling slot that would fall past the last slot is dropped. Holding `fsync_i` high does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Highway bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync; its rising edge starts a frame |
| slot_i | input | $clog2(NSLOT) | Assigned time-slot number |
| data_i | input | 8 | Companded sample byte |
| cd1_i | input | 1 | Debounced detector 1 status |
| cd2_i | input | 1 | Detector 2 status |
| cfail_i | input | 1 | Clock-fail status |
| dbl_clk_i | input | 1 | Half-rate bit clock select |
| sig_mode_i | input | 1 | Append signaling slot |
| comp_en_i | input | 1 | Companded mode selected |
| chan_act_i | input | 1 | Channel active |
| dout_o | output | 1 | Serial data |
| doe_o | output | 1 | Drive enable for the tri-state buffer |

## Verification
The bench builds the block with NSLOT=8. A full frame is then 64 bit periods, or 128 clocks in double-clock mode, so many complete frames fit in a short run. Every slot number, including the last one where the signaling slot drops off the frame end, is reachable by random choice. Directed frames cover inactive channels, disabled companding, held frame sync and mid-frame input changes.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  typedef struct packed {
    logic dbl;
    logic smode;
    logic comp;
    logic act;
  } slot_cfg_t;

  function automatic logic [7:0] sig_byte(logic cd1, logic cd2, logic cfail);
    return {cd1, cd2, 3'b000, cfail, 2'b00};
  endfunction
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int NSLOT = 32,
  localparam int END_POS = NSLOT * 8,
  localparam int POS_W = $clog2(END_POS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             dbl_i,
  output logic             fs_rise_o,
  output logic [POS_W-1:0] pos_o
);
  logic fs_q, ph_q;
  logic [POS_W-1:0] pos_q;

  assign fs_rise_o = fsync_i & ~fs_q;
  assign pos_o     = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      ph_q  <= 1'b0;
      pos_q <= POS_W'(END_POS);
    end else begin
      fs_q <= fsync_i;
      if (fs_rise_o) begin
        pos_q <= '0;
        ph_q  <= 1'b0;
      end else if (pos_q != POS_W'(END_POS)) begin
        if (!dbl_i || ph_q) pos_q <= pos_q + 1'b1;
        ph_q <= dbl_i & ~ph_q;
      end
    end
  end

  AST_FS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_rise_o |=> pos_q == '0); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fs_rise_o && !dbl_i && pos_q != POS_W'(END_POS)) |=> pos_q == $past(pos_q) + 1'b1); // R3
  AST_DOUBLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fs_rise_o && dbl_i && !ph_q) |=> $stable(pos_q)); // R4
  AST_END_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fs_rise_o && pos_q == POS_W'(END_POS)) |=> pos_q == POS_W'(END_POS)); // R11
endmodule

// File: rtl/pcm_slot_sel.sv
module pcm_slot_sel #(
  parameter int NSLOT = 32,
  localparam int END_POS = NSLOT * 8,
  localparam int POS_W = $clog2(END_POS + 1),
  localparam int IDX_W = POS_W - 3,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic [POS_W-1:0]        pos_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  pcm_slot_pkg::slot_cfg_t cfg_i,
  input  logic [7:0]              data_i,
  input  logic [7:0]              sig_i,
  output logic                    data_hit_o,
  output logic                    sig_hit_o,
  output logic                    dout_o
);
  logic             in_frame;
  logic [IDX_W-1:0] idx, own;
  logic [2:0]       bitn;

  assign in_frame = pos_i < POS_W'(END_POS);
  assign idx      = pos_i[POS_W-1:3];
  assign bitn     = pos_i[2:0];
  assign own      = IDX_W'(slot_i);

  assign data_hit_o = in_frame && cfg_i.act && (idx == own);
  assign sig_hit_o  = in_frame && cfg_i.smode && cfg_i.comp && (idx == own + IDX_W'(1));

  always_comb begin
    dout_o = 1'b0;
    if (data_hit_o)     dout_o = data_i[~bitn];
    else if (sig_hit_o) dout_o = sig_i[~bitn];
  end
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx #(
  parameter int NSLOT = 32,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int POS_W = $clog2(NSLOT * 8 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [7:0]        data_i,
  input  logic              cd1_i,
  input  logic              cd2_i,
  input  logic              cfail_i,
  input  logic              dbl_clk_i,
  input  logic              sig_mode_i,
  input  logic              comp_en_i,
  input  logic              chan_act_i,
  output logic              dout_o,
  output logic              doe_o
);
  import pcm_slot_pkg::*;

  slot_cfg_t         cfg_q;
  logic [SLOT_W-1:0] slot_q;
  logic [7:0]        data_q, sig_q;
  logic              fs_rise, data_hit, sig_hit;
  logic [POS_W-1:0]  pos;

  // frame-start capture of everything the frame uses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      slot_q <= '0;
      data_q <= '0;
      sig_q  <= '0;
    end else if (fs_rise) begin
      cfg_q  <= '{dbl: dbl_clk_i, smode: sig_mode_i, comp: comp_en_i, act: chan_act_i};
      slot_q <= slot_i;
      data_q <= data_i;
      sig_q  <= sig_byte(cd1_i, cd2_i, cfail_i);
    end
  end

  pcm_slot_timer #(.NSLOT(NSLOT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fsync_i   (fsync_i),
    .dbl_i     (cfg_q.dbl),
    .fs_rise_o (fs_rise),
    .pos_o     (pos)
  );

  pcm_slot_sel #(.NSLOT(NSLOT)) u_sel (
    .pos_i      (pos),
    .slot_i     (slot_q),
    .cfg_i      (cfg_q),
    .data_i     (data_q),
    .sig_i      (sig_q),
    .data_hit_o (data_hit),
    .sig_hit_o  (sig_hit),
    .dout_o     (dout_o)
  );

  assign doe_o = data_hit | sig_hit;

  AST_SIG_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_hit |-> (cfg_q.smode && cfg_q.comp)); // R7
  AST_INACTIVE_SIG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (doe_o && !cfg_q.act) |-> sig_hit); // R8
  AST_QUIET_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !doe_o |-> !dout_o); // R9
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_rise |=> $stable(cfg_q) && $stable(data_q) && $stable(slot_q)); // R10
endmodule

// File: tb/tb_pcm_slot_tx.sv
`timescale 1ns/1ps
module tb_pcm_slot_tx;
  localparam int NSLOT = 8;
  localparam int SW = $clog2(NSLOT);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fsync = 1'b0;
  logic [SW-1:0] slot = '0;
  logic [7:0] data = '0;
  logic cd1 = 0, cd2 = 0, cfail = 0, dbl = 0, smode = 0, comp = 0, act = 0;
  logic dout, doe;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_slot_tx #(.NSLOT(NSLOT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .slot_i(slot), .data_i(data),
    .cd1_i(cd1), .cd2_i(cd2), .cfail_i(cfail), .dbl_clk_i(dbl),
    .sig_mode_i(smode), .comp_en_i(comp), .chan_act_i(act),
    .dout_o(dout), .doe_o(doe)
  );

  // frame snapshot for the model
  int f_slot; logic [7:0] f_data, f_sig; logic f_dbl, f_sm, f_cp, f_act;

  // returns {region(2), oe, d}; region 0 none, 1 data, 2 sig
  function automatic logic [3:0] model(int t);
    int p, idx, b;
    p = f_dbl ? t / 2 : t;
    if (p >= NSLOT * 8) return 4'b0000;
    idx = p / 8; b = p % 8;
    if (f_act && idx == f_slot) return {2'd1, 1'b1, f_data[7-b]};
    if (f_sm && f_cp && idx == f_slot + 1) return {2'd2, 1'b1, f_sig[7-b]};
    return 4'b0000;
  endfunction

  task automatic chk(string tag, logic [1:0] ea, logic ed, int t);
    checks++;
    if (doe !== ea[0] || dout !== ed) begin
      errors++;
      $display("FAIL %s t=%0d actual oe=%b d=%b expected oe=%b d=%b", tag, t, doe, dout, ea[0], ed);
    end
  endtask

  task automatic randomize_inputs();
    slot = SW'($urandom); data = 8'($urandom);
    cd1 = 1'($urandom); cd2 = 1'($urandom); cfail = 1'($urandom);
    dbl = 1'($urandom); smode = 1'($urandom); comp = 1'($urandom); act = 1'($urandom);
  endtask

  // inputs must be set before call; runs one frame, fs high for hold cycles
  task automatic run_frame(string ftag, int hold, bit churn);
    logic [3:0] e;
    string tag;
    f_slot = slot; f_data = data; f_sig = {cd1, cd2, 3'b000, cfail, 2'b00};
    f_dbl = dbl; f_sm = smode; f_cp = comp; f_act = act;
    fsync = 1'b1;
    for (int t = 0; t < NSLOT * 8 * (f_dbl ? 2 : 1) + 4; t++) begin
      @(negedge clk);
      if (t >= hold - 1) fsync = 1'b0;
      e = model(t);
      case (e[3:2])
        2'd1: tag = f_dbl ? "R5/R4" : "R5/R3";
        2'd2: tag = "R6";
        default: tag = "R9";
      endcase
      chk({tag, "/", ftag}, {1'b0, e[1]}, e[0], t);
      if (churn && t == 2) randomize_inputs(); // R10: must not matter
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", 2'b00, 1'b0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", 2'b00, 1'b0, 0);

    // directed: R7 companding off
    slot = 3; data = 8'hA5; cd1 = 1; cd2 = 1; cfail = 1; dbl = 0; smode = 1; comp = 0; act = 1;
    run_frame("R7", 1, 0);
    // R8 inactive channel, signaling still sent
    comp = 1; act = 0; dbl = 1;
    run_frame("R8", 1, 0);
    // R11 last slot: signaling falls off frame; held sync
    slot = NSLOT - 1; act = 1; dbl = 0; data = 8'h3C;
    run_frame("R11", 5, 0);
    // R6 gapless data then signaling, slot 0
    slot = 0; data = 8'h81; cd1 = 1; cd2 = 0; cfail = 1;
    run_frame("R6", 1, 0);
    // R10 churn
    for (int i = 0; i < 4; i++) begin
      randomize_inputs();
      run_frame("R10", 1, 1);
    end
    // random R2 frames
    for (int i = 0; i < 12; i++) begin
      randomize_inputs();
      run_frame("R2", 1 + ($urandom % 3), 1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule